// File: doc/BRIEF.md
# Signed Array Multiplier

This block multiplies two signed two's-complement operands of equal width and returns the full-width signed product. The arithmetic is a regular grid of carry-save cells built with generate loops. Each row of the grid handles one multiplier bit. A closing row of full adders resolves the sums and carries that are still pending.

Signed operation does not rely on sign extension. The partial-product bits that pair exactly one operand sign bit with a non-sign bit are complemented. Two constant ones are then injected into the outer adders of the closing row, and the result is kept modulo 2^(2·WIDTH).

The array itself is combinational. Its result is captured in an output register that has a synchronous active-high reset, so a product appears one clock after its operands are presented. The operand width is the parameter `WIDTH`, which must be at least 2 and defaults to 4.

Top module: `bw_mult`

## Requirements
- R1: On a clock edge with `rst` low, `p` takes the signed product of `a` and `b`, both read as two's complement, reduced modulo 2^(2·WIDTH). The new value is visible after that edge, so the latency is one cycle.
- R2: On a clock edge with `rst` high, `p` becomes all zeros, whatever the values on `a` and `b`.
- R3: The most negative operand times itself (for WIDTH=4, -8 × -8) gives +2^(2·WIDTH-2) (0x40 for WIDTH=4), with bit 2·WIDTH-1 clear.
- R4: When both operands are nonzero, bit 2·WIDTH-1 of `p` equals the XOR of bit WIDTH-1 of `a` and bit WIDTH-1 of `b`.
- R5: If either operand is zero, `p` is zero on the next cycle.
- R6: While `a` and `b` are held unchanged, `p` stays unchanged from the second cycle onward.
- R7: The result is correct at WIDTH=6 and WIDTH=8, including the extreme operands (most negative, most positive, 0 and -1).
- R8: The most negative operand times the most positive one (for WIDTH=4, -8 × 7) gives -(2^(2·WIDTH-2) - 2^(WIDTH-1)) (0xC8 for WIDTH=4).
- R9: Multiplying by -1 gives the negation of the other operand, sign-extended to 2·WIDTH bits. For WIDTH=4, -8 × -1 = 0x08 and 0 × -1 = 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | Multiplicand, two's complement |
| b | input | WIDTH | Multiplier, two's complement |
| p | output | 2·WIDTH | Registered signed product |

## Verification
On every cycle, the assertions compare the registered product with a sign-extended reference product of the operands from the previous cycle. They also check that reset clears the output, that zero operands and the extreme square behave correctly, that the sign bit follows the operand signs, and that the output is stable while the inputs are held. They cannot show that every one of the complemented cells and constant injections is wired correctly across the whole operand space. The bench's exhaustive sweep at WIDTH=4 and its random and extreme-value runs at WIDTH=6 and WIDTH=8 show that.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

  // A partial-product bit is complemented when exactly one of its
  // operand bits is a sign bit.
  function automatic bit pp_is_inverted(input int col, input int row, input int width);
    return (col == width - 1) != (row == width - 1);
  endfunction

endpackage

// File: rtl/bw_full_add.sv
module bw_full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (x & ci) | (y & ci);
endmodule

// File: rtl/bw_cell.sv
module bw_cell #(
  parameter bit INVERT = 1'b0
) (
  input  logic a_bit,
  input  logic b_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);
  logic pp;

  generate
    if (INVERT) begin : g_nand
      assign pp = ~(a_bit & b_bit);
    end else begin : g_and
      assign pp = a_bit & b_bit;
    end
  endgenerate

  bw_full_add u_fa (
    .x  (pp),
    .y  (sum_in),
    .ci (carry_in),
    .s  (sum_out),
    .co (carry_out)
  );
endmodule

// File: rtl/bw_final_row.sv
module bw_final_row #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-2:0] upper_sum,
  input  logic [WIDTH-1:0] low_carry,
  output logic [WIDTH-1:0] hi
);
  localparam int W = WIDTH;

  // rip[0] is the injected +2^W correction.
  logic [W-1:0] rip;
  assign rip[0] = 1'b1;

  generate
    for (genvar k = 0; k < W; k++) begin : g_col
      if (k < W - 1) begin : g_full
        bw_full_add u_fa (
          .x  (upper_sum[k]),
          .y  (low_carry[k]),
          .ci (rip[k]),
          .s  (hi[k]),
          .co (rip[k+1])
        );
      end else begin : g_top
        // The injected constant one (weight 2^(2W-1)) is the operand here.
        // The carry out of this position lies beyond the product and is dropped.
        assign hi[k] = ~(low_carry[k] ^ rip[k]);
      end
    end
  endgenerate
endmodule

// File: rtl/bw_array.sv
module bw_array #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] prod
);
  import bw_mult_pkg::*;

  localparam int W = WIDTH;

  wire [W-1:0] s_row [W];
  wire [W-1:0] c_row [W];

  generate
    for (genvar j = 0; j < W; j++) begin : g_row
      for (genvar i = 0; i < W; i++) begin : g_col
        logic sin_w;
        logic cin_w;
        if (j == 0) begin : g_first
          assign sin_w = 1'b0;
          assign cin_w = 1'b0;
        end else begin : g_next
          assign cin_w = c_row[j-1][i];
          if (i == W - 1) begin : g_edge
            assign sin_w = 1'b0;
          end else begin : g_diag
            assign sin_w = s_row[j-1][i+1];
          end
        end

        bw_cell #(.INVERT(pp_is_inverted(i, j, W))) u_cell (
          .a_bit     (a[i]),
          .b_bit     (b[j]),
          .sum_in    (sin_w),
          .carry_in  (cin_w),
          .sum_out   (s_row[j][i]),
          .carry_out (c_row[j][i])
        );
      end
      // Each row retires one low-order product bit.
      assign prod[j] = s_row[j][0];
    end
  endgenerate

  bw_final_row #(.WIDTH(W)) u_final (
    .upper_sum (s_row[W-1][W-1:1]),
    .low_carry (c_row[W-1]),
    .hi        (prod[2*W-1:W])
  );
endmodule

// File: rtl/bw_mult.sv
module bw_mult #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] p
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] prod_c;

  bw_array #(.WIDTH(WIDTH)) u_array (
    .a    (a),
    .b    (b),
    .prod (prod_c)
  );

  always_ff @(posedge clk) begin
    if (rst) p <= '0;
    else     p <= prod_c;
  end
endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH-1:0]   b,
  input logic [2*WIDTH-1:0] p
);
  localparam int W  = WIDTH;
  localparam int PW = 2 * WIDTH;
  localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] NEG_SQ   = {2'b01, {(PW-2){1'b0}}};

  // Reference: multiply the sign-extended operands and keep PW bits.
  logic [PW-1:0] exp_c;
  always_comb exp_c = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};

  p_product_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> p == $past(exp_c));

  p_reset_zero_r2: assert property (@(posedge clk)
    rst |=> p == '0);

  p_extreme_sq_r3: assert property (@(posedge clk) disable iff (rst)
    (a == MOST_NEG && b == MOST_NEG) |=> p == NEG_SQ);

  p_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (a != '0 && b != '0) |=> p[PW-1] == ($past(a[W-1]) ^ $past(b[W-1])));

  p_zero_op_r5: assert property (@(posedge clk) disable iff (rst)
    (a == '0 || b == '0) |=> p == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(a) && $stable(b)) |=> $stable(p));
endmodule

bind bw_mult bw_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk (clk),
  .rst (rst),
  .a   (a),
  .b   (b),
  .p   (p)
);

// File: tb/bw_mult_tb.sv
module bw_mult_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;
  logic [5:0]  a6 = '0, b6 = '0;
  logic [11:0] p6;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;

  bw_mult #(.WIDTH(4)) u_dut  (.clk(clk), .rst(rst), .a(a4), .b(b4), .p(p4));
  bw_mult #(.WIDTH(6)) u_dut6 (.clk(clk), .rst(rst), .a(a6), .b(b6), .p(p6));
  bw_mult #(.WIDTH(8)) u_dut8 (.clk(clk), .rst(rst), .a(a8), .b(b8), .p(p8));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {a, b, expected product}, WIDTH=4
  localparam logic [15:0] VEC [8] = '{
    {4'h8, 4'h8, 8'h40},  // R3: -8 * -8
    {4'h8, 4'h7, 8'hC8},  // R8: -8 * 7
    {4'h0, 4'hF, 8'h00},  // R9: 0 * -1
    {4'h8, 4'hF, 8'h08},  // R9: -8 * -1
    {4'h7, 4'h7, 8'h31},  // R1: 7 * 7
    {4'hF, 4'hF, 8'h01},  // R1: -1 * -1
    {4'h8, 4'h1, 8'hF8},  // R1: -8 * 1
    {4'h3, 4'hB, 8'hF1}   // R1: 3 * -5
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_mul(input int x, input int y);
    int r = x * y;
    return r[15:0];
  endfunction

  function automatic logic [7:0] pick8(input int k, input logic [7:0] rnd, input int w);
    logic [7:0] mn = 8'(1 << (w - 1));
    case (k % 5)
      0: return mn;
      1: return mn - 8'd1;
      2: return 8'd0;
      3: return 8'hFF;
      default: return rnd;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: outputs clear while in reset
    check("R2 reset w4", 16'(p4), 16'h0);
    check("R2 reset w6", 16'(p6), 16'h0);
    check("R2 reset w8", p8, 16'h0);
    rst = 1'b0;

    // Table walk
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      a4 = VEC[v][15:12];
      b4 = VEC[v][11:8];
      @(negedge clk);
      check($sformatf("R1 R3 R8 R9 table entry %0d", v), 16'(p4), 16'(VEC[v][7:0]));
    end

    // R1: exhaustive sweep at WIDTH=4
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        @(negedge clk);
        a4 = 4'(ai);
        b4 = 4'(bi);
        @(negedge clk);
        check("R1 exhaustive w4", 16'(p4),
              16'(ref_mul(int'($signed(a4)), int'($signed(b4))) & 16'h00FF));
      end
    end

    // R7: random and extreme vectors at WIDTH=6 and WIDTH=8
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] r6 = 8'($urandom);
      logic [7:0] s6 = 8'($urandom);
      logic [7:0] r8 = 8'($urandom);
      logic [7:0] s8 = 8'($urandom);
      @(negedge clk);
      if (n < 100) begin
        a6 = 6'(pick8(n, r6, 6));
        b6 = 6'(pick8(n / 5, s6, 6));
        a8 = pick8(n, r8, 8);
        b8 = pick8(n / 5, s8, 8);
      end else begin
        a6 = r6[5:0];
        b6 = s6[5:0];
        a8 = r8;
        b8 = s8;
      end
      @(negedge clk);
      check("R7 width 6", 16'(p6),
            ref_mul(int'($signed(a6)), int'($signed(b6))) & 16'h0FFF);
      check("R7 width 8", p8, ref_mul(int'($signed(a8)), int'($signed(b8))));
    end

    // R4: sign follows operand signs
    @(negedge clk); a4 = 4'hD; b4 = 4'h5;  // -3 * 5 = -15
    @(negedge clk); check("R4 sign bit", 16'(p4[7]), 16'h1);
    @(negedge clk); a4 = 4'hD; b4 = 4'hE;  // -3 * -2 = 6
    @(negedge clk); check("R4 sign bit", 16'(p4[7]), 16'h0);

    // R5: zero operand gives zero
    @(negedge clk); a4 = 4'h8; b4 = 4'h0;
    @(negedge clk); check("R5 zero operand", 16'(p4), 16'h0);

    // R6: held inputs keep the output steady
    @(negedge clk); a4 = 4'h5; b4 = 4'hA;  // 5 * -6 = -30 = 0xE2
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check("R6 hold", 16'(p4), 16'h00E2);
    end

    // R2: reset overrides nonzero operands mid-run
    @(negedge clk); a4 = 4'h8; b4 = 4'h8; rst = 1'b1;
    @(negedge clk); check("R2 reset override", 16'(p4), 16'h0);
    rst = 1'b0;
    @(negedge clk); check("R3 after reset", 16'(p4), 16'h0040);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule